// File: doc/BRIEF.md
# AES-256 Round-Key Expansion Loader (Data and Tweak Channels)

This block takes a 256-bit AES key and expands it into the fifteen 128-bit round keys that an AES-256 cipher datapath uses. It then holds them until a new key arrives. Two identical, fully independent channels sit side by side. One serves the data-encryption key and the other serves the tweak key of a tweakable storage cipher. Either channel can start a load at any time, including while the other channel is loading.

Each channel has a one-cycle key-valid strobe, a busy flag, a one-cycle finish pulse and a sticky "keys loaded" flag. Expansion takes a fixed sequence of 14 clock cycles:

- The first cycle stores round keys 0 and 1, which are the two halves of the input key.
- Each later cycle derives and stores one more round key.

A strobe that arrives while the channel is busy is dropped. The stored round keys can be read at any time through a combinational read port indexed by round number.

Top module: `xks_pair`

## Requirements
- R1: After the active-low reset, busy, finish and loaded are 0 on both channels.
- R2: A key-valid strobe that is sampled while the channel is idle sets busy high from the next cycle. Busy then stays high for exactly 14 consecutive cycles.
- R3: Finish is high for exactly one cycle, which is the 14th (last) busy cycle. Busy is low in the cycle after finish.
- R4: A key-valid strobe that is sampled while busy is high is ignored. The busy length is unchanged, and the stored round keys are those of the key that started the load.
- R5: Round key 0 equals key bits [255:128] and round key 1 equals key bits [127:0]. Words are big-endian: bits [127:96] of a round key are its first word.
- R6: Round keys 2 to 14 follow the AES-256 expansion. For an even round k, the last word of round k-1 is rotated left by one byte, passed through the S-box, and XORed in its top byte with the constant 2^(k/2-1) in GF(2^8). For an odd round k, that word is passed through the S-box only. The result is XORed into the words of round k-2 as a running chain.
- R7: Loaded rises in the cycle after the first finish and stays high until reset. The stored keys stay unchanged until a later accepted strobe replaces them.
- R8: The two channels are independent. Loads that overlap in time both produce correct keys and correct busy and finish timing, and a load on one channel leaves the other channel's flags and keys untouched.
- R9: A read index of 15 returns all zeros on either channel.
- R10: A strobe in the finish cycle is ignored. A strobe in the first cycle after busy falls starts a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dk_valid | input | 1 | Data-key load strobe |
| dk_key | input | 256 | Data key, valid with dk_valid |
| dk_busy | output | 1 | Data-key expansion in progress |
| dk_finish | output | 1 | Last cycle of data-key expansion |
| dk_loaded | output | 1 | A data-key set has completed since reset |
| dk_rd_idx | input | 4 | Data-key round index to read |
| dk_rd_key | output | 128 | Data-key round key at dk_rd_idx |
| tk_valid | input | 1 | Tweak-key load strobe |
| tk_key | input | 256 | Tweak key, valid with tk_valid |
| tk_busy | output | 1 | Tweak-key expansion in progress |
| tk_finish | output | 1 | Last cycle of tweak-key expansion |
| tk_loaded | output | 1 | A tweak-key set has completed since reset |
| tk_rd_idx | input | 4 | Tweak-key round index to read |
| tk_rd_key | output | 128 | Tweak-key round key at tk_rd_idx |

## Verification
Two pairs of events can land in the same cycle.

- **Two channels expanding at once.** The bench starts the tweak-key load three cycles after the data-key load, so the two busy windows overlap for eleven cycles. It then checks each channel's busy and finish cycle by cycle, and compares both full key sets against an independent expansion model.
- **A new strobe meeting the last expansion cycle.** The bench drives a strobe exactly in the finish cycle and expects it to be dropped. It drives another in the first idle cycle after finish and expects that one to be taken. The stored keys show which key won.

// File: rtl/xks_pkg.sv
package xks_pkg;

  typedef logic [7:0]  byte_t;
  typedef logic [31:0] word_t;

  // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_xtime(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // Inverse as a^254 (maps 0 to 0)
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r;
    byte_t p;
    logic [7:0] e;
    r = 8'h01;
    p = a;
    e = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t rotl8(input byte_t b, input int unsigned n);
    byte_t r;
    r = b;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(n)) r = {r[6:0], r[7]};
    end
    return r;
  endfunction

  // Forward S-box: field inverse followed by the affine map
  function automatic byte_t sbox(input byte_t a);
    byte_t v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic word_t rot_word(input word_t w);
    return {w[23:0], w[31:24]};
  endfunction

  // Round constant for pair number n (n = 1 gives 8'h01)
  function automatic byte_t rcon_byte(input logic [3:0] n);
    byte_t c;
    c = 8'h01;
    for (int i = 1; i < 15; i++) begin
      if (i < int'(n)) c = gf_xtime(c);
    end
    return c;
  endfunction

endpackage

// File: rtl/xks_step.sv
// One expansion step: derives round key k from keys k-2 and k-1.
module xks_step
  import xks_pkg::*;
#(
  parameter int unsigned RK_W  = 128,
  parameter int unsigned IDX_W = 4
) (
  input  logic [RK_W-1:0]  older,
  input  logic [RK_W-1:0]  newer,
  input  logic [IDX_W-1:0] rk_idx,
  output logic [RK_W-1:0]  next_rk
);
  localparam int unsigned NWORDS = RK_W / 32;

  logic        odd_step;
  word_t       src_word;
  word_t       sub_out;
  word_t       mix_word;
  byte_t       rc;
  word_t       chain [NWORDS];

  assign odd_step = rk_idx[0];
  // R6: even steps rotate, odd steps do not
  assign src_word = odd_step ? newer[31:0] : rot_word(newer[31:0]);
  assign rc       = rcon_byte(4'(rk_idx >> 1));

  for (genvar b = 0; b < 4; b++) begin : g_sub
    assign sub_out[8*b +: 8] = sbox(src_word[8*b +: 8]);
  end

  assign mix_word = odd_step ? sub_out : (sub_out ^ {rc, 24'h000000});

  for (genvar w = 0; w < NWORDS; w++) begin : g_chain
    if (w == 0) begin : g_head
      assign chain[w] = older[RK_W-1 -: 32] ^ mix_word;
    end else begin : g_tail
      assign chain[w] = older[RK_W-1-32*w -: 32] ^ chain[w-1];
    end
    assign next_rk[RK_W-1-32*w -: 32] = chain[w];
  end

endmodule

// File: rtl/xks_store.sv
// Round-key storage with two write ports and an indexed read port.
module xks_store #(
  parameter int unsigned NUM_RK = 15,
  parameter int unsigned RK_W   = 128,
  parameter int unsigned IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  logic [RK_W-1:0]  wa_data,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [RK_W-1:0]  wb_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RK_W-1:0]  rd_data
);
  logic [RK_W-1:0] mem [NUM_RK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NUM_RK); i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < int'(NUM_RK); i++) begin
        if (wa_en && (wa_idx == IDX_W'(i)))      mem[i] <= wa_data;
        else if (wb_en && (wb_idx == IDX_W'(i))) mem[i] <= wb_data;
      end
    end
  end

  // R9: indices past the last round key read as zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < int'(NUM_RK); i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = mem[i];
    end
  end

endmodule

// File: rtl/xks_channel.sv
// One key channel: strobe capture, 14-cycle sequencing, storage.
module xks_channel #(
  parameter int unsigned KEY_W  = 256,
  parameter int unsigned NUM_RK = 15,
  parameter int unsigned IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  input  logic [KEY_W-1:0] key_in,
  output logic             busy,
  output logic             finish,
  output logic             loaded,
  output logic             accept,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [KEY_W/2-1:0] rd_key
);
  localparam int unsigned RK_W        = KEY_W / 2;
  localparam int unsigned LOAD_CYCLES = NUM_RK - 1;
  localparam int unsigned CNT_W       = $clog2(LOAD_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LOAD_CYCLES - 1);

  logic             busy_q;
  logic             loaded_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RK_W-1:0]  older_q;
  logic [RK_W-1:0]  newer_q;
  logic [RK_W-1:0]  step_out;
  logic [IDX_W-1:0] step_idx;
  logic             first_step;
  logic             last_step;

  // R4/R10: a strobe is taken only while idle
  assign accept     = key_valid && !busy_q;
  assign first_step = busy_q && (cnt_q == '0);
  assign last_step  = busy_q && (cnt_q == LAST_CNT);
  assign step_idx   = IDX_W'(cnt_q) + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      loaded_q <= 1'b0;
      cnt_q    <= '0;
      older_q  <= '0;
      newer_q  <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      older_q <= key_in[KEY_W-1 -: RK_W];
      newer_q <= key_in[RK_W-1:0];
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_step) begin
        busy_q   <= 1'b0;
        loaded_q <= 1'b1;
      end
      if (!first_step) begin
        older_q <= newer_q;
        newer_q <= step_out;
      end
    end
  end

  xks_step #(
    .RK_W  (RK_W),
    .IDX_W (IDX_W)
  ) u_step (
    .older   (older_q),
    .newer   (newer_q),
    .rk_idx  (step_idx),
    .next_rk (step_out)
  );

  // R5: first busy cycle stores both key halves; later cycles one step each
  xks_store #(
    .NUM_RK (NUM_RK),
    .RK_W   (RK_W),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (busy_q),
    .wa_idx  (first_step ? IDX_W'(0) : step_idx),
    .wa_data (first_step ? older_q : step_out),
    .wb_en   (first_step),
    .wb_idx  (IDX_W'(1)),
    .wb_data (newer_q),
    .rd_idx  (rd_idx),
    .rd_data (rd_key)
  );

  assign busy   = busy_q;
  assign finish = last_step;
  assign loaded = loaded_q;

endmodule

// File: rtl/xks_pair.sv
// Data-key and tweak-key expansion loaders side by side (R8).
module xks_pair #(
  parameter int unsigned KEY_W  = 256,
  parameter int unsigned NUM_RK = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dk_valid,
  input  logic [KEY_W-1:0]           dk_key,
  output logic                       dk_busy,
  output logic                       dk_finish,
  output logic                       dk_loaded,
  input  logic [$clog2(NUM_RK)-1:0]  dk_rd_idx,
  output logic [KEY_W/2-1:0]         dk_rd_key,
  input  logic                       tk_valid,
  input  logic [KEY_W-1:0]           tk_key,
  output logic                       tk_busy,
  output logic                       tk_finish,
  output logic                       tk_loaded,
  input  logic [$clog2(NUM_RK)-1:0]  tk_rd_idx,
  output logic [KEY_W/2-1:0]         tk_rd_key
);
  localparam int unsigned IDX_W = $clog2(NUM_RK);

  logic dk_accept;
  logic tk_accept;

  xks_channel #(
    .KEY_W  (KEY_W),
    .NUM_RK (NUM_RK),
    .IDX_W  (IDX_W)
  ) u_dk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (dk_valid),
    .key_in    (dk_key),
    .busy      (dk_busy),
    .finish    (dk_finish),
    .loaded    (dk_loaded),
    .accept    (dk_accept),
    .rd_idx    (dk_rd_idx),
    .rd_key    (dk_rd_key)
  );

  xks_channel #(
    .KEY_W  (KEY_W),
    .NUM_RK (NUM_RK),
    .IDX_W  (IDX_W)
  ) u_tk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (tk_valid),
    .key_in    (tk_key),
    .busy      (tk_busy),
    .finish    (tk_finish),
    .loaded    (tk_loaded),
    .accept    (tk_accept),
    .rd_idx    (tk_rd_idx),
    .rd_key    (tk_rd_key)
  );

endmodule

// File: rtl/xks_pair_chk.sv
module xks_chan_chk #(
  parameter int unsigned NUM_RK = 15,
  parameter int unsigned RK_W   = 128,
  parameter int unsigned IDX_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid,
  input logic             busy,
  input logic             finish,
  input logic             loaded,
  input logic             accept,
  input logic [IDX_W-1:0] rd_idx,
  input logic [RK_W-1:0]  rd_key
);
  localparam int unsigned LOAD_CYCLES = NUM_RK - 1;
  localparam int unsigned CW = $clog2(LOAD_CYCLES + 1) + 1;

  logic [CW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !finish));
  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy);
  a_r2_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < CW'(LOAD_CYCLES)));
  a_r3_finish_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> busy);
  a_r3_finish_count: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (busy_run == CW'(LOAD_CYCLES - 1)));
  a_r3_finish_drop: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!busy && !finish));
  a_r4_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && busy && !finish) |=> (busy && $stable(busy_run + 1'b0) == 1'b0));
  a_r7_loaded_set: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> loaded);
  a_r7_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);
  a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= IDX_W'(NUM_RK)) |-> (rd_key == '0));

endmodule

bind xks_pair xks_chan_chk #(.NUM_RK(NUM_RK), .RK_W(KEY_W/2), .IDX_W($clog2(NUM_RK))) u_chk_dk (
  .clk(clk), .rst_n(rst_n), .valid(dk_valid), .busy(dk_busy), .finish(dk_finish),
  .loaded(dk_loaded), .accept(dk_accept), .rd_idx(dk_rd_idx), .rd_key(dk_rd_key));

bind xks_pair xks_chan_chk #(.NUM_RK(NUM_RK), .RK_W(KEY_W/2), .IDX_W($clog2(NUM_RK))) u_chk_tk (
  .clk(clk), .rst_n(rst_n), .valid(tk_valid), .busy(tk_busy), .finish(tk_finish),
  .loaded(tk_loaded), .accept(tk_accept), .rd_idx(tk_rd_idx), .rd_key(tk_rd_key));

// File: tb/xks_pair_bench.sv
module xks_pair_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dk_valid = 1'b0, tk_valid = 1'b0;
  logic [255:0] dk_key = '0, tk_key = '0;
  logic         dk_busy, dk_finish, dk_loaded, tk_busy, tk_finish, tk_loaded;
  logic [3:0]   dk_rd_idx = '0, tk_rd_idx = '0;
  logic [127:0] dk_rd_key, tk_rd_key;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0]   inv_t [256];
  logic [127:0] exp_dk [15];
  logic [127:0] exp_tk [15];

  localparam logic [255:0] KEY_STD = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [255:0] KEY_B   = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
  localparam logic [255:0] KEY_C   = {32{8'ha5}};
  localparam logic [255:0] KEY_D   = 256'hffeeddccbbaa99887766554433221100f0e1d2c3b4a5968778695a4b3c2d1e0f;
  localparam logic [255:0] KEY_Z   = '0;

  always #4 clk = ~clk;

  xks_pair u_xks_pair (
    .clk(clk), .rst_n(rst_n),
    .dk_valid(dk_valid), .dk_key(dk_key), .dk_busy(dk_busy), .dk_finish(dk_finish),
    .dk_loaded(dk_loaded), .dk_rd_idx(dk_rd_idx), .dk_rd_key(dk_rd_key),
    .tk_valid(tk_valid), .tk_key(tk_key), .tk_busy(tk_busy), .tk_finish(tk_finish),
    .tk_loaded(tk_loaded), .tk_rd_idx(tk_rd_idx), .tk_rd_key(tk_rd_key)
  );

  // ---------------- reference model ----------------
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] b, s, c;
    b = inv_t[x];
    c = 8'h63;
    for (int i = 0; i < 8; i++)
      s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ c[i];
    return s;
  endfunction

  function automatic logic [31:0] ref_sub(input logic [31:0] w);
    return {ref_sbox(w[31:24]), ref_sbox(w[23:16]), ref_sbox(w[15:8]), ref_sbox(w[7:0])};
  endfunction

  task automatic model(input bit ch, input logic [255:0] k);
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 8; i++) w[i] = k[255-32*i -: 32];
    for (int i = 8; i < 60; i++) begin
      t = w[i-1];
      if (i % 8 == 0) begin
        t = ref_sub({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = ref_mul(rc, 8'h02);
      end else if (i % 8 == 4) begin
        t = ref_sub(t);
      end
      w[i] = w[i-8] ^ t;
    end
    for (int r = 0; r < 15; r++) begin
      if (ch) exp_tk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
      else    exp_dk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    end
  endtask

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input bit ch, input logic v, input logic [255:0] k);
    if (ch) begin tk_valid = v; tk_key = k; end
    else    begin dk_valid = v; dk_key = k; end
  endtask

  function automatic logic get_busy(input bit ch);
    return ch ? tk_busy : dk_busy;
  endfunction

  function automatic logic get_fin(input bit ch);
    return ch ? tk_finish : dk_finish;
  endfunction

  // Called at the negedge where a strobe was just driven; watches 15 cycles.
  task automatic watch(input bit ch, input int dup1, input int dup2,
                       input logic [255:0] dupkey, input string req);
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (k == dup1 || k == dup2) drive(ch, 1'b1, dupkey);
      else                        drive(ch, 1'b0, dupkey);
      #1;
      chk({req, " busy"},   128'(get_busy(ch)), 128'(k <= 14));
      chk({req, " finish"}, 128'(get_fin(ch)),  128'(k == 14));
    end
  endtask

  task automatic read_all(input bit ch, input string req);
    for (int r = 0; r < 15; r++) begin
      if (ch) tk_rd_idx = 4'(r); else dk_rd_idx = 4'(r);
      #1;
      if (ch) chk(req, tk_rd_key, exp_tk[r]);
      else    chk(req, dk_rd_key, exp_dk[r]);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 dk_busy",   128'(dk_busy),   '0);
    chk("R1 dk_finish", 128'(dk_finish), '0);
    chk("R1 dk_loaded", 128'(dk_loaded), '0);
    chk("R1 tk_busy",   128'(tk_busy),   '0);
    chk("R1 tk_finish", 128'(tk_finish), '0);
    chk("R1 tk_loaded", 128'(tk_loaded), '0);
  endtask

  task automatic t_known_answer();
    @(negedge clk);
    drive(1'b0, 1'b1, KEY_STD);
    watch(1'b0, -1, -1, KEY_STD, "R2 R3 known");
    model(1'b0, KEY_STD);
    dk_rd_idx = 4'd0; #1;
    chk("R5 rk0 half", dk_rd_key, KEY_STD[255:128]);
    dk_rd_idx = 4'd1; #1;
    chk("R5 rk1 half", dk_rd_key, KEY_STD[127:0]);
    dk_rd_idx = 4'd2; #1;
    chk("R6 rk2 known", dk_rd_key, 128'ha573c29fa176c498a97fce93a572c09c);
    dk_rd_idx = 4'd14; #1;
    chk("R6 rk14 known", dk_rd_key, 128'h24fc79ccbf0979e9371ac23c6d68de36);
    read_all(1'b0, "R6 model");
    chk("R7 loaded", 128'(dk_loaded), 128'd1);
    chk("R8 tk untouched", 128'(tk_loaded), '0);
    tk_rd_idx = 4'd0; #1;
    chk("R8 tk keys untouched", tk_rd_key, '0);
  endtask

  task automatic t_ignore_busy();
    @(negedge clk);
    drive(1'b0, 1'b1, KEY_B);
    // strobes mid-load (R4) and in the finish cycle (R10) are dropped
    watch(1'b0, 5, 14, KEY_C, "R4 R10 ignore");
    model(1'b0, KEY_B);
    read_all(1'b0, "R4 keys of first");
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    drive(1'b0, 1'b1, KEY_Z);
    watch(1'b0, -1, 15, KEY_D, "R10 first");
    watch(1'b0, -1, -1, KEY_D, "R10 second");
    model(1'b0, KEY_D);
    read_all(1'b0, "R10 R7 replaced");
  endtask

  task automatic t_overlap();
    @(negedge clk);
    drive(1'b0, 1'b1, KEY_C);
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      drive(1'b0, 1'b0, KEY_C);
      drive(1'b1, (k == 3), KEY_STD);
      #1;
      chk("R8 dk busy",   128'(dk_busy),   128'(k <= 14));
      chk("R8 dk finish", 128'(dk_finish), 128'(k == 14));
      chk("R8 tk busy",   128'(tk_busy),   128'(k >= 4 && k <= 17));
      chk("R8 tk finish", 128'(tk_finish), 128'(k == 17));
    end
    model(1'b0, KEY_C);
    model(1'b1, KEY_STD);
    read_all(1'b0, "R8 dk keys");
    read_all(1'b1, "R8 tk keys");
    chk("R7 tk loaded", 128'(tk_loaded), 128'd1);
  endtask

  task automatic t_out_of_range();
    dk_rd_idx = 4'd15; tk_rd_idx = 4'd15; #1;
    chk("R9 dk idx15", dk_rd_key, '0);
    chk("R9 tk idx15", tk_rd_key, '0);
  endtask

  task automatic t_persist();
    repeat (40) @(negedge clk);
    chk("R7 dk loaded held", 128'(dk_loaded), 128'd1);
    read_all(1'b0, "R7 dk held");
    read_all(1'b1, "R7 tk held");
  endtask

  initial begin
    inv_t[0] = 8'h00;
    for (int x = 1; x < 256; x++)
      for (int y = 1; y < 256; y++)
        if (ref_mul(8'(x), 8'(y)) == 8'h01) inv_t[x] = 8'(y);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_known_answer();
    t_ignore_busy();
    t_back_to_back();
    t_overlap();
    t_out_of_range();
    t_persist();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule